// File: doc/BRIEF.md
# Nearest-Neighbor Video Field Scaler

This block resizes a progressive video field carried on a valid/ready pixel stream. Each input beat carries one 4:4:4 pixel with a start-of-field marker and an end-of-line marker. Input and output widths and heights are held in a small write-only register port. Their reset values come from parameters, so a system that never writes them still gets a fixed size. Output coordinate n in a direction takes its pixel from input index floor(n × input size / output size). Horizontal and vertical ratios are independent, and either direction can be bypassed so that its output size follows its input size.

Each input line is first stored whole in one internal line buffer. It is then read out as zero or more output lines. A line that is dropped by vertical downscaling produces no output. A line that vertical upscaling repeats is read out again while the input side is held off. The sizes are checked against the block's parameter limits when a field starts. A field with an illegal size or a sampling code other than 4:4:4 is accepted and thrown away without producing output, and a sticky error flag is raised.

Top module: `nn_scaler`

## Requirements
- R1: A field with legal settings produces exactly out_w × out_h output beats, where out_w and out_h are the effective sizes of that field.
- R2: The output pixel at column n and row m equals the input pixel at column floor(n·in_w/out_w) and row floor(m·in_h/out_h). The two directions are computed independently.
- R3: out_sof is high only on the first output beat of a field. out_eol is high only on the last beat of each output line.
- R4: The bypass register is at address 5. Its bit 0 disables horizontal scaling and its bit 1 disables vertical scaling. A disabled direction's output size equals its input size, whatever the output-size register holds.
- R5: If the input width is 0 or larger than MAX_IN_W at start of field, the field produces no output and err_flag rises on the cycle after the start-of-field beat.
- R6: The field is treated the same way as in R5 if the effective output width is 0 or larger than MAX_OUT_W, or if the input height or effective output height is 0.
- R7: in_fmt is sampled on the start-of-field beat, where code 0 means 4:4:4. Any other code drops the field and raises err_flag.
- R8: err_flag stays high until a write to address 4. Later legal fields are still processed while the flag is high.
- R9: Size and bypass registers are taken only on the start-of-field beat. A write during a field applies from the next field on. The register addresses are 0 for input width, 1 for input height, 2 for output width and 3 for output height.
- R10: During and right after reset, out_valid and err_flag are low and in_ready is high.
- R11: in_ready is low on every cycle in which out_valid is high, including while an input line is being repeated.
- R12: While out_valid is high and out_ready is low, out_valid, out_data and the markers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | DW | Register write data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | PW | Input pixel |
| in_sof | input | 1 | First beat of a field |
| in_eol | input | 1 | Last beat of a line |
| in_fmt | input | 2 | Sampling code, 0 = 4:4:4 |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | PW | Output pixel |
| out_sof | output | 1 | First output beat of a field |
| out_eol | output | 1 | Last beat of an output line |
| err_flag | output | 1 | Sticky illegal-setting flag |

## Verification
The first output beat of a line is due two cycles after its end-of-line beat is accepted. One cycle is spent deciding whether the line is repeated or dropped, and the output then becomes valid on the following cycle and stays valid until taken. Because output timing depends on backpressure and on the ratios, the bench does not count a fixed latency. It collects output beats until the expected product of sizes has arrived, then watches ten more cycles so that any extra beat is caught. The error flag is registered and is due one cycle after the start-of-field beat. The bench reads it only after the whole field has been sent. Inputs and out_ready change on the falling edge and outputs are sampled one time unit later, so every sample reflects the state settled after the last rising edge.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_CHK, ST_EMIT} scl_st_e;
  localparam logic [2:0] A_IN_W  = 3'd0;
  localparam logic [2:0] A_IN_H  = 3'd1;
  localparam logic [2:0] A_OUT_W = 3'd2;
  localparam logic [2:0] A_OUT_H = 3'd3;
  localparam logic [2:0] A_CLR   = 3'd4;
  localparam logic [2:0] A_BYP   = 3'd5;
endpackage

// File: rtl/scl_cfg.sv
module scl_cfg
  import scl_pkg::*;
#(
  parameter int DW = 12,
  parameter int DEF_IN_W = 8,
  parameter int DEF_IN_H = 4,
  parameter int DEF_OUT_W = 8,
  parameter int DEF_OUT_H = 4,
  parameter logic [1:0] DEF_BYP = 2'b00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] in_w,
  output logic [DW-1:0] in_h,
  output logic [DW-1:0] out_w,
  output logic [DW-1:0] out_h,
  output logic [1:0]    byp,
  output logic          clr
);
  logic en_iw, en_ih, en_ow, en_oh, en_byp;

  always_comb begin
    en_iw  = we && (addr == A_IN_W);
    en_ih  = we && (addr == A_IN_H);
    en_ow  = we && (addr == A_OUT_W);
    en_oh  = we && (addr == A_OUT_H);
    en_byp = we && (addr == A_BYP);
    clr    = we && (addr == A_CLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_w  <= DW'(DEF_IN_W);
      in_h  <= DW'(DEF_IN_H);
      out_w <= DW'(DEF_OUT_W);
      out_h <= DW'(DEF_OUT_H);
      byp   <= DEF_BYP;
    end else begin
      if (en_iw)  in_w  <= wdata;
      if (en_ih)  in_h  <= wdata;
      if (en_ow)  out_w <= wdata;
      if (en_oh)  out_h <= wdata;
      if (en_byp) byp   <= wdata[1:0];
    end
  end
endmodule

// File: rtl/nn_step.sv
module nn_step #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          take,
  input  logic          adv,
  input  logic [DW-1:0] init_src,
  input  logic [DW-1:0] init_dst,
  output logic          hit,
  output logic [DW-1:0] src_q,
  output logic [DW-1:0] dst_q,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] idx_q
);
  localparam int AW = 2 * DW + 1;

  // acc_q tracks cnt*src, bnd_q tracks (idx+1)*dst
  logic [AW-1:0] acc_q, acc_d, bnd_q, bnd_d;
  logic [DW-1:0] src_d, dst_d, cnt_d, idx_d;
  logic          en;

  assign hit = (acc_q < bnd_q) && (cnt_q < dst_q);

  always_comb begin
    en    = init | take | adv;
    acc_d = acc_q;
    bnd_d = bnd_q;
    src_d = src_q;
    dst_d = dst_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (init) begin
      src_d = init_src;
      dst_d = init_dst;
      acc_d = '0;
      bnd_d = AW'(init_dst);
      cnt_d = '0;
      idx_d = '0;
    end else begin
      if (take) begin
        acc_d = acc_q + AW'(src_q);
        cnt_d = cnt_q + 1'b1;
      end
      if (adv) begin
        bnd_d = bnd_q + AW'(dst_q);
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      bnd_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (en) begin
      acc_q <= acc_d;
      bnd_q <= bnd_d;
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  // R2: an output is only produced for a source index that maps to it
  p_take_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hit);
  // R2: producing and advancing never happen together
  p_take_adv_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && adv));
  // R1: the output count never passes the output size
  p_cnt_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= dst_q);
endmodule

// File: rtl/scl_linebuf.sv
module scl_linebuf #(
  parameter int DEPTH = 64,
  parameter int PW = 24,
  localparam int LAW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           we,
  input  logic [LAW-1:0] waddr,
  input  logic [PW-1:0]  wdata,
  input  logic [LAW-1:0] raddr,
  output logic [PW-1:0]  rdata
);
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nn_scaler.sv
module nn_scaler
  import scl_pkg::*;
#(
  parameter int DW = 12,
  parameter int PW = 24,
  parameter int MAX_IN_W = 64,
  parameter int MAX_OUT_W = 128,
  parameter int DEF_IN_W = 8,
  parameter int DEF_IN_H = 4,
  parameter int DEF_OUT_W = 8,
  parameter int DEF_OUT_H = 4,
  parameter logic [1:0] DEF_BYP = 2'b00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eol,
  input  logic [1:0]    in_fmt,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eol,
  output logic          err_flag
);
  localparam int LAW = (MAX_IN_W > 1) ? $clog2(MAX_IN_W) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic [DW-1:0] c_iw, c_ih, c_ow, c_oh, e_ow, e_oh;
  logic [1:0]    c_byp;
  logic          c_clr, cfg_bad;

  scl_cfg #(.DW(DW), .DEF_IN_W(DEF_IN_W), .DEF_IN_H(DEF_IN_H),
            .DEF_OUT_W(DEF_OUT_W), .DEF_OUT_H(DEF_OUT_H), .DEF_BYP(DEF_BYP)) u_cfg (
    .clk(clk), .rst_n(rst_sn), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .in_w(c_iw), .in_h(c_ih), .out_w(c_ow), .out_h(c_oh), .byp(c_byp), .clr(c_clr));

  always_comb begin
    e_ow    = c_byp[0] ? c_iw : c_ow;
    e_oh    = c_byp[1] ? c_ih : c_oh;
    cfg_bad = (c_iw == '0) || (c_iw > DW'(MAX_IN_W)) || (c_ih == '0) ||
              (e_ow == '0) || (e_ow > DW'(MAX_OUT_W)) || (e_oh == '0) ||
              (in_fmt != 2'd0);
  end

  scl_st_e       st_q, st_d;
  logic [DW-1:0] wptr_q, wptr_d, s_iw_q, s_iw_d, s_ow_q, s_ow_d;
  logic          sof_pend_q, sof_pend_d, err_q, err_d;
  logic          v_init, v_adv, v_hit, h_init, h_take, h_adv, h_hit, line_done;
  logic [DW-1:0] v_src, v_dst, v_cnt, v_idx, h_src, h_dst, h_cnt, h_idx;
  logic          buf_we;
  logic [LAW-1:0] buf_waddr;

  nn_step #(.DW(DW)) u_vstep (
    .clk(clk), .rst_n(rst_sn), .init(v_init), .take(line_done), .adv(v_adv),
    .init_src(c_ih), .init_dst(e_oh), .hit(v_hit),
    .src_q(v_src), .dst_q(v_dst), .cnt_q(v_cnt), .idx_q(v_idx));

  nn_step #(.DW(DW)) u_hstep (
    .clk(clk), .rst_n(rst_sn), .init(h_init), .take(h_take), .adv(h_adv),
    .init_src(s_iw_q), .init_dst(s_ow_q), .hit(h_hit),
    .src_q(h_src), .dst_q(h_dst), .cnt_q(h_cnt), .idx_q(h_idx));

  scl_linebuf #(.DEPTH(MAX_IN_W), .PW(PW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(in_data),
    .raddr(h_idx[LAW-1:0]), .rdata(out_data));

  assign in_ready  = (st_q == ST_IDLE) || (st_q == ST_LOAD);
  assign out_valid = (st_q == ST_EMIT) && h_hit;
  assign out_eol   = out_valid && (h_cnt == h_dst - 1'b1);
  assign out_sof   = out_valid && sof_pend_q;
  assign h_take    = out_valid && out_ready;
  assign h_adv     = (st_q == ST_EMIT) && !h_hit;
  assign line_done = h_take && (h_cnt == h_dst - 1'b1);
  assign err_flag  = err_q;

  always_comb begin
    st_d       = st_q;
    wptr_d     = wptr_q;
    s_iw_d     = s_iw_q;
    s_ow_d     = s_ow_q;
    sof_pend_d = sof_pend_q;
    err_d      = err_q;
    v_init     = 1'b0;
    v_adv      = 1'b0;
    h_init     = 1'b0;
    buf_we     = 1'b0;
    buf_waddr  = wptr_q[LAW-1:0];
    if (c_clr) err_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (in_valid && in_sof) begin
          if (cfg_bad) begin
            err_d = 1'b1;
          end else begin
            v_init     = 1'b1;
            s_iw_d     = c_iw;
            s_ow_d     = e_ow;
            sof_pend_d = 1'b1;
            buf_we     = 1'b1;
            buf_waddr  = '0;
            wptr_d     = DW'(1);
            st_d       = in_eol ? ST_CHK : ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        if (in_valid) begin
          buf_we = wptr_q < DW'(MAX_IN_W);
          wptr_d = wptr_q + 1'b1;
          if (in_eol) st_d = ST_CHK;
        end
      end
      ST_CHK: begin
        wptr_d = '0;
        if (v_hit) begin
          h_init = 1'b1;
          st_d   = ST_EMIT;
        end else begin
          v_adv = 1'b1;
          st_d  = (v_idx == v_src - 1'b1) ? ST_IDLE : ST_LOAD;
        end
      end
      ST_EMIT: begin
        if (line_done) st_d = ST_CHK;
      end
      default: st_d = ST_IDLE;
    endcase
    if (h_take) sof_pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q       <= ST_IDLE;
      wptr_q     <= '0;
      s_iw_q     <= '0;
      s_ow_q     <= '0;
      sof_pend_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      wptr_q     <= wptr_d;
      s_iw_q     <= s_iw_d;
      s_ow_q     <= s_ow_d;
      sof_pend_q <= sof_pend_d;
      err_q      <= err_d;
    end
  end

  // R12: a stalled output beat holds
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_eol) && $stable(out_sof)));
  // R8: the flag only falls on a clear write
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (err_flag && !(cfg_we && cfg_addr == A_CLR)) |=> err_flag);
  // R5: a rejected field start leaves the block idle with the flag set
  p_reject_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_IDLE && in_valid && in_sof && cfg_bad) |=> (err_flag && !out_valid));
  // R3: start-of-field marks one beat only
  p_sof_once_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && out_ready) |=> !out_sof);
endmodule

// File: tb/nn_scaler_tb_top.sv
module nn_scaler_tb_top;
  localparam int DW = 12, PW = 24, MIW = 64, MOW = 128, NV = 10;
  // iw, ih, ow, oh, bypass, expected ow, expected oh
  localparam int VEC [NV][7] = '{
    '{8, 4, 8, 4, 0, 8, 4},
    '{8, 4, 16, 8, 0, 16, 8},
    '{8, 6, 5, 3, 0, 5, 3},
    '{5, 3, 12, 7, 0, 12, 7},
    '{7, 5, 3, 9, 0, 3, 9},
    '{4, 4, 9, 2, 1, 4, 2},
    '{4, 3, 6, 8, 2, 6, 3},
    '{64, 2, 128, 3, 0, 128, 3},
    '{6, 2, 1, 1, 0, 1, 1},
    '{3, 3, 40, 1, 3, 3, 3}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_we, in_valid, in_ready, in_sof, in_eol, out_valid, out_ready;
  logic out_sof, out_eol, err_flag;
  logic [2:0] cfg_addr;
  logic [DW-1:0] cfg_wdata;
  logic [PW-1:0] in_data, out_data;
  logic [1:0] in_fmt;

  nn_scaler #(.DW(DW), .PW(PW), .MAX_IN_W(MIW), .MAX_OUT_W(MOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
    .in_eol(in_eol), .in_fmt(in_fmt), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol), .err_flag(err_flag));

  int checks = 0, errors = 0, ncap = 0, ready_viol = 0, fld = 0;
  bit done = 1'b0;
  logic [PW-1:0] cap_d [1024];
  logic cap_sof [1024];
  logic cap_eol [1024];
  logic [15:0] lfsr = 16'hACE1;

  always begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = lfsr[0] | lfsr[1];
    #1;
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (in_ready) ready_viol++;
      if (out_ready) begin
        if (ncap < 1024) begin
          cap_d[ncap] = out_data;
          cap_sof[ncap] = out_sof;
          cap_eol[ncap] = out_eol;
        end
        ncap++;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, int d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = DW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [PW-1:0] pix(int x, int y, int f);
    return {8'(f), 8'(y), 8'(x)};
  endfunction

  task automatic send(logic [PW-1:0] d, bit s, bit e, logic [1:0] fm);
    in_valid = 1'b1; in_data = d; in_sof = s; in_eol = e; in_fmt = fm;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_field(bit do_cfg, int iw, int ih, int ow, int oh, int byp,
                           logic [1:0] fm, int mid_ow, int eow, int eoh);
    int exp_n, t, bad_d, bad_f, first_a, first_e;
    fld++;
    if (do_cfg) begin
      wr(3'd0, iw); wr(3'd1, ih); wr(3'd2, ow); wr(3'd3, oh); wr(3'd5, byp);
    end
    ncap = 0; ready_viol = 0;
    for (int y = 0; y < ih; y++) begin
      for (int x = 0; x < iw; x++) send(pix(x, y, fld), (x == 0 && y == 0), (x == iw - 1), fm);
      if (y == 0 && mid_ow >= 0) wr(3'd2, mid_ow);
    end
    exp_n = eow * eoh;
    t = 0;
    while (ncap < exp_n && t < 4000) begin @(negedge clk); t++; end
    repeat (10) @(negedge clk);
    #1;
    chk(ncap == exp_n, "R1", "beat count", ncap, exp_n);
    if (exp_n > 0) begin
      bad_d = 0; bad_f = 0; first_a = 0; first_e = 0;
      for (int k = 0; k < exp_n && k < ncap && k < 1024; k++) begin
        int n = k % eow, m = k / eow;
        logic [PW-1:0] e = pix((n * iw) / eow, (m * ih) / eoh, fld);
        if (cap_d[k] !== e) begin
          if (bad_d == 0) begin first_a = int'(cap_d[k]); first_e = int'(e); end
          bad_d++;
        end
        if (cap_sof[k] !== (k == 0) || cap_eol[k] !== (n == eow - 1)) bad_f++;
      end
      chk(bad_d == 0, "R2", "first wrong pixel", first_a, first_e);
      chk(bad_f == 0, "R3", "framing marker errors", bad_f, 0);
      chk(ready_viol == 0, "R11", "in_ready high with out_valid", ready_viol, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eol = 1'b0; in_fmt = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    chk(err_flag == 1'b0, "R10", "err_flag in reset", err_flag, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0 && err_flag == 1'b0, "R10", "outputs after reset", out_valid, 0);
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_field(1'b1, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 2'd0, -1,
                VEC[v][5], VEC[v][6]);
      if (VEC[v][4] != 0)  // R4 bypass size
        chk(ncap == VEC[v][5] * VEC[v][6], "R4", "bypass size", ncap, VEC[v][5] * VEC[v][6]);
    end

    // R5: input width over limit
    run_field(1'b1, 65, 2, 4, 2, 0, 2'd0, -1, 0, 0);
    chk(err_flag == 1'b1, "R5", "flag after wide input", err_flag, 1);
    // R8: sticky, legal field still processed
    run_field(1'b1, 4, 2, 8, 4, 0, 2'd0, -1, 8, 4);
    chk(err_flag == 1'b1, "R8", "flag held without clear", err_flag, 1);
    wr(3'd4, 0);
    #1;
    chk(err_flag == 1'b0, "R8", "flag after clear", err_flag, 0);
    // R6: output width over limit, zero output width
    run_field(1'b1, 4, 2, 129, 2, 0, 2'd0, -1, 0, 0);
    chk(err_flag == 1'b1, "R6", "flag wide output", err_flag, 1);
    wr(3'd4, 0);
    run_field(1'b1, 4, 2, 0, 2, 0, 2'd0, -1, 0, 0);
    chk(err_flag == 1'b1, "R6", "flag zero output", err_flag, 1);
    wr(3'd4, 0);
    // R7: non-4:4:4 sampling
    run_field(1'b1, 4, 2, 4, 2, 0, 2'd2, -1, 0, 0);
    chk(err_flag == 1'b1, "R7", "flag bad sampling", err_flag, 1);
    wr(3'd4, 0);
    // R9: mid-field write applies next field
    run_field(1'b1, 6, 3, 8, 5, 0, 2'd0, 4, 8, 5);
    run_field(1'b0, 6, 3, 8, 5, 0, 2'd0, -1, 4, 5);
    chk(ncap == 20, "R9", "next-field width", ncap, 20);
    chk(err_flag == 1'b0, "R9", "no flag for legal fields", err_flag, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule